// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt lines and turns them into two requests for a processor: a normal request and a fast request. Every line has its own enable bit, a routing bit that chooses normal or fast handling, a 4-bit priority and a 32-bit handler address. Software reaches all of this through a small synchronous register bus.

Among the pending normal lines that pass the priority mask, the controller picks the one with the highest priority and reports its number in a status word. It also reports the number of the pending fast line. Two lookup words return the handler address of each current winner, so an exception handler can jump to it with a single read. Lines are switched on and off by writing a line number to a set register or a clear register. This lets software change one line without a read-modify-write.

Top module: `vic_ctrl`

## Requirements
- R1: After reset both request outputs are low. Control, mask, enable, routing, priority and handler-table words read zero. Word 0x40 reads 0xFFFF0000 and word 0x44 reads 0xFFFFFFFF.
- R2: Writing a line number to 0x08 sets that line's enable bit, and writing it to 0x0C clears it. No other enable bit changes. A written value of 64 or more changes nothing. Enables read back at 0x10 (lines 63..32) and 0x14 (lines 31..0).
- R3: Routing word 0x18 holds lines 63..32 and word 0x1C holds lines 31..0. Bit value 1 routes a line as fast and 0 routes it as normal.
- R4: The priority of line n is the nibble at bits 4·(n mod 8)+3 : 4·(n mod 8) of word 0x20 + 4·(7 − n div 8).
- R5: irq_o is high exactly when some line is high, enabled, routed normal and not masked. It follows a change on src_i one clock edge later.
- R6: Word 0x40 carries the winning normal line in bits 31:16, and 0xFFFF there when none is pending. Bits 15:0 read zero. The highest priority wins, and a tie goes to the higher line number.
- R7: Mask word 0x04 is 5 bits wide. When bit 4 is set, every priority passes. Otherwise a normal line passes only if its priority is greater than bits 3:0.
- R8: fiq_o is high exactly when some line is high, enabled and routed fast. Word 0x44 reads the highest such line number, or 0xFFFFFFFF when there is none.
- R9: The handler table holds 64 read/write words, entry n at 0x100 + 4·n.
- R10: Word 0x48 returns the table entry of the normal winner when control bit 0 is set, and 0 otherwise or with no winner. Word 0x4C returns the table entry of the fast winner, or 0.
- R11: Control word 0x00 stores only bit 0 and the mask stores only bits 4:0. Other bits read zero. A read returns its data on bus_rdata after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level interrupt lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a state where routing, enable, priority and mask interact. Several lines must be high at once: some with equal priority, some routed fast, some held back by the mask. Then the normal and fast winners differ, and each depends on a different one of those controls. The stimulus builds that state in layers. It first sets priorities that tie and differ, then moves the mask threshold across them. After that it re-routes one of the tied lines as fast and enables a higher-numbered fast line. After each layer it reads both status words and both lookup words.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int SRC_CNT  = 64;
    localparam int PRI_W    = 4;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = $clog2(SRC_CNT);
    localparam int MASK_W   = PRI_W + 1;
    localparam int ADDR_W   = 10;

    // byte offsets of the register words
    localparam logic [ADDR_W-1:0] A_CTRL  = 10'h000;
    localparam logic [ADDR_W-1:0] A_MASK  = 10'h004;
    localparam logic [ADDR_W-1:0] A_ENSET = 10'h008;
    localparam logic [ADDR_W-1:0] A_ENCLR = 10'h00C;
    localparam logic [ADDR_W-1:0] A_ENHI  = 10'h010;
    localparam logic [ADDR_W-1:0] A_ENLO  = 10'h014;
    localparam logic [ADDR_W-1:0] A_TYPHI = 10'h018;
    localparam logic [ADDR_W-1:0] A_TYPLO = 10'h01C;
    localparam logic [ADDR_W-1:0] A_PRIO  = 10'h020;
    localparam logic [ADDR_W-1:0] A_NSTAT = 10'h040;
    localparam logic [ADDR_W-1:0] A_FSTAT = 10'h044;
    localparam logic [ADDR_W-1:0] A_NVEC  = 10'h048;
    localparam logic [ADDR_W-1:0] A_FVEC  = 10'h04C;
    localparam logic [ADDR_W-1:0] A_VTAB  = 10'h100;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        logic             vld;
        logic [PRI_W-1:0] pri;
        logic [IDX_W-1:0] idx;
    } node_t;

    // higher-index candidate wins on equal priority
    function automatic node_t pick_node(node_t lo, node_t hi);
        if (hi.vld && (!lo.vld || hi.pri >= lo.pri))
            return hi;
        return lo;
    endfunction

    function automatic logic mask_pass(logic [MASK_W-1:0] m, logic [PRI_W-1:0] p);
        return m[MASK_W-1] || (p > m[PRI_W-1:0]);
    endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_CNT,
    parameter int PW   = PRI_W,
    parameter int DW   = WORD_W,
    parameter int AW   = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic [IDX_W-1:0]    n_idx,
    input  logic [IDX_W-1:0]    f_idx,
    output logic                ctrl_en,
    output logic [MASK_W-1:0]   mask,
    output logic [NSRC-1:0]     en_vec,
    output logic [NSRC-1:0]     typ_vec,
    output logic [NSRC*PW-1:0]  prio_flat,
    output logic [DW-1:0]       n_vec,
    output logic [DW-1:0]       f_vec,
    output logic [DW-1:0]       cfg_rdata
);
    localparam int NIB_PER_REG = DW / PW;
    localparam int PRIO_REGS   = NSRC / NIB_PER_REG;
    localparam int PSEL_W      = $clog2(PRIO_REGS);
    localparam int HALF        = NSRC / 2;

    logic [DW-1:0] prio_q [PRIO_REGS];
    logic [DW-1:0] vtab_q [NSRC];
    logic          is_prio, is_vtab;
    logic [PSEL_W-1:0] psel;
    logic [IDX_W-1:0]  vsel;
    logic              num_ok;

    assign psel    = addr[PSEL_W+1:2];
    assign vsel    = addr[IDX_W+1:2];
    assign is_prio = (addr >= A_PRIO) && (addr < A_PRIO + AW'(4*PRIO_REGS));
    assign is_vtab = (addr >= A_VTAB) && (addr < A_VTAB + AW'(4*NSRC));
    assign num_ok  = (wdata[DW-1:IDX_W] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            mask    <= '0;
            en_vec  <= '0;
            typ_vec <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL:  ctrl_en <= wdata[0];
                A_MASK:  mask    <= wdata[MASK_W-1:0];
                A_ENSET: if (num_ok) en_vec[wdata[IDX_W-1:0]] <= 1'b1;
                A_ENCLR: if (num_ok) en_vec[wdata[IDX_W-1:0]] <= 1'b0;
                A_TYPHI: typ_vec[NSRC-1:HALF] <= wdata[HALF-1:0];
                A_TYPLO: typ_vec[HALF-1:0]    <= wdata[HALF-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PRIO_REGS; k++) prio_q[k] <= '0;
        end else if (wr_en && is_prio) begin
            prio_q[psel] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSRC; k++) vtab_q[k] <= '0;
        end else if (wr_en && is_vtab) begin
            vtab_q[vsel] <= wdata;
        end
    end

    // word (PRIO_REGS-1 - n/NIB_PER_REG) holds line n
    for (genvar n = 0; n < NSRC; n++) begin : g_pri
        assign prio_flat[n*PW +: PW] =
            prio_q[PRIO_REGS-1 - n/NIB_PER_REG][(n%NIB_PER_REG)*PW +: PW];
    end

    assign n_vec = vtab_q[n_idx];
    assign f_vec = vtab_q[f_idx];

    always_comb begin
        cfg_rdata = '0;
        if (is_prio)
            cfg_rdata = prio_q[psel];
        else if (is_vtab)
            cfg_rdata = vtab_q[vsel];
        else begin
            case (addr)
                A_CTRL:  cfg_rdata = DW'(ctrl_en);
                A_MASK:  cfg_rdata = DW'(mask);
                A_ENHI:  cfg_rdata = DW'(en_vec[NSRC-1:HALF]);
                A_ENLO:  cfg_rdata = DW'(en_vec[HALF-1:0]);
                A_TYPHI: cfg_rdata = DW'(typ_vec[NSRC-1:HALF]);
                A_TYPLO: cfg_rdata = DW'(typ_vec[HALF-1:0]);
                default: cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NSRC    = SRC_CNT,
    parameter int PW      = PRI_W,
    parameter bit USE_PRI = 1'b1
) (
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC*PW-1:0] pri_flat,
    output logic               win_vld,
    output logic [IDX_W-1:0]   win_idx
);
    localparam int NODES = 2*NSRC - 1;

    node_t heap [NODES];

    // leaves: heap[NSRC-1+i] is line i, ascending left to right
    for (genvar i = 0; i < NSRC; i++) begin : g_leaf
        if (USE_PRI) begin : g_p
            assign heap[NSRC-1+i] = '{vld: req[i], pri: pri_flat[i*PW +: PW],
                                      idx: IDX_W'(i)};
        end else begin : g_np
            assign heap[NSRC-1+i] = '{vld: req[i], pri: '0, idx: IDX_W'(i)};
        end
    end

    for (genvar k = 0; k < NSRC-1; k++) begin : g_node
        assign heap[k] = pick_node(heap[2*k+1], heap[2*k+2]);
    end

    assign win_vld = heap[0].vld;
    assign win_idx = heap[0].idx;

    logic unused_pri;
    assign unused_pri = USE_PRI ? 1'b0 : ^pri_flat;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_CNT,
    parameter int PW   = PRI_W,
    parameter int DW   = WORD_W,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int HW = DW / 2;

    acc_e               acc;
    logic [NSRC-1:0]    src_q;
    logic               ctrl_en;
    logic [MASK_W-1:0]  mask;
    logic [NSRC-1:0]    en_vec, typ_vec, cand_n, cand_f;
    logic [NSRC*PW-1:0] prio_flat;
    logic [DW-1:0]      n_vec, f_vec, cfg_rdata, rd_mux;
    logic               n_vld, f_vld;
    logic [IDX_W-1:0]   n_idx, f_idx;

    always_comb begin
        if (!bus_sel)    acc = ACC_IDLE;
        else if (bus_wr) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_i;
    end

    vic_regs #(.NSRC(NSRC), .PW(PW), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc == ACC_WRITE),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .n_idx    (n_idx),
        .f_idx    (f_idx),
        .ctrl_en  (ctrl_en),
        .mask     (mask),
        .en_vec   (en_vec),
        .typ_vec  (typ_vec),
        .prio_flat(prio_flat),
        .n_vec    (n_vec),
        .f_vec    (f_vec),
        .cfg_rdata(cfg_rdata)
    );

    for (genvar n = 0; n < NSRC; n++) begin : g_cand
        assign cand_n[n] = src_q[n] & en_vec[n] & ~typ_vec[n]
                         & mask_pass(mask, prio_flat[n*PW +: PW]);
        assign cand_f[n] = src_q[n] & en_vec[n] & typ_vec[n];
    end

    vic_arbiter #(.NSRC(NSRC), .PW(PW), .USE_PRI(1'b1)) u_narb (
        .req     (cand_n),
        .pri_flat(prio_flat),
        .win_vld (n_vld),
        .win_idx (n_idx)
    );

    vic_arbiter #(.NSRC(NSRC), .PW(PW), .USE_PRI(1'b0)) u_farb (
        .req     (cand_f),
        .pri_flat(prio_flat),
        .win_vld (f_vld),
        .win_idx (f_idx)
    );

    assign irq_o = n_vld;
    assign fiq_o = f_vld;

    always_comb begin
        case (bus_addr)
            A_NSTAT: rd_mux = n_vld ? {HW'(n_idx), HW'(0)} : {{HW{1'b1}}, HW'(0)};
            A_FSTAT: rd_mux = f_vld ? DW'(f_idx) : {DW{1'b1}};
            A_NVEC:  rd_mux = (n_vld && ctrl_en) ? n_vec : '0;
            A_FVEC:  rd_mux = f_vld ? f_vec : '0;
            default: rd_mux = cfg_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (acc == ACC_READ) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
#(
    parameter int NSRC = SRC_CNT
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             fiq_o,
    input logic [NSRC-1:0]  src_q,
    input logic [NSRC-1:0]  en_vec,
    input logic [NSRC-1:0]  typ_vec,
    input logic [IDX_W-1:0] n_idx,
    input logic [IDX_W-1:0] f_idx
);
    logic [NSRC-1:0] fast_live, norm_live;
    assign fast_live = src_q & en_vec & typ_vec;
    assign norm_live = src_q & en_vec & ~typ_vec;

    // R1: requests quiet after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) rst |=> (!irq_o && !fiq_o));

    // R2: one enable bit at most changes per cycle
    p_enable_single_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(en_vec ^ $past(en_vec)) <= 1);

    // R5: normal request needs a live normal line
    p_irq_has_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (norm_live != '0));

    // R6: reported normal winner is itself live
    p_norm_winner_live_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> norm_live[n_idx]);

    // R8: fast request needs a live fast line
    p_fiq_has_source_r8: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (fast_live != '0));

    // R8: no higher-numbered fast line than the reported one
    p_fiq_top_index_r8: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (((fast_live >> f_idx) >> 1) == '0));
endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o),
    .src_q  (src_q),
    .en_vec (en_vec),
    .typ_vec(typ_vec),
    .n_idx  (n_idx),
    .f_idx  (f_idx)
);

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [31:0] pri_sh [8];

    always #5 clk = ~clk;

    vic_ctrl uut (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(string req, logic [9:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd_reg(a, d);
        chk(req, d, exp);
    endtask

    task automatic drive_src(logic [63:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    // line n: word 0x20 + 4*(7 - n/8), nibble n%8
    task automatic set_pri(int n, logic [3:0] p);
        int w;
        w = 7 - n / 8;
        pri_sh[w][(n % 8)*4 +: 4] = p;
        wr_reg(10'h020 + 10'(4*w), pri_sh[w]);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        rd_chk("R1 ctrl", 10'h000, 0);
        rd_chk("R1 mask", 10'h004, 0);
        rd_chk("R1 enlo", 10'h014, 0);
        rd_chk("R1 typhi", 10'h018, 0);
        rd_chk("R1 prio", 10'h03C, 0);
        rd_chk("R1 vtab", 10'h1FC, 0);
        rd_chk("R1 nstat", 10'h040, 32'hFFFF_0000);
        rd_chk("R1 fstat", 10'h044, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        wr_reg(10'h008, 5);
        wr_reg(10'h008, 40);
        wr_reg(10'h008, 63);
        rd_chk("R2 enhi", 10'h010, 32'h8000_0100);
        rd_chk("R2 enlo", 10'h014, 32'h0000_0020);
        wr_reg(10'h00C, 40);
        rd_chk("R2 clr40", 10'h010, 32'h8000_0000);
        wr_reg(10'h008, 64);
        wr_reg(10'h00C, 32'h0000_0105);
        rd_chk("R2 oob hi", 10'h010, 32'h8000_0000);
        rd_chk("R2 oob lo", 10'h014, 32'h0000_0020);
        wr_reg(10'h00C, 5);
        wr_reg(10'h00C, 63);
        rd_chk("R2 cleared", 10'h010, 0);
    endtask

    task automatic t_type_ctrl();
        wr_reg(10'h018, 32'h0000_0001);
        wr_reg(10'h01C, 32'h8000_0000);
        rd_chk("R3 typhi", 10'h018, 32'h0000_0001);
        rd_chk("R3 typlo", 10'h01C, 32'h8000_0000);
        wr_reg(10'h008, 32);
        drive_src(64'h1 << 32);
        chk("R3 line32 fast fiq", 32'(fiq), 1);
        chk("R3 line32 fast irq", 32'(irq), 0);
        drive_src('0);
        wr_reg(10'h00C, 32);
        wr_reg(10'h018, 0);
        wr_reg(10'h01C, 0);
        wr_reg(10'h000, 32'hFFFF_FFFF);
        wr_reg(10'h004, 32'hFFFF_FFFF);
        rd_chk("R11 ctrl bits", 10'h000, 32'h1);
        rd_chk("R11 mask bits", 10'h004, 32'h1F);
        wr_reg(10'h000, 0);
    endtask

    task automatic t_prio();
        set_pri(0, 4'hA);
        set_pri(63, 4'h5);
        set_pri(9, 4'h3);
        rd_chk("R4 line0", 10'h03C, 32'h0000_000A);
        rd_chk("R4 line63", 10'h020, 32'h5000_0000);
        rd_chk("R4 line9", 10'h038, 32'h0000_0030);
        set_pri(0, 0); set_pri(63, 0); set_pri(9, 0);
    endtask

    task automatic t_arb();
        wr_reg(10'h008, 3); wr_reg(10'h008, 10); wr_reg(10'h008, 20);
        set_pri(3, 7); set_pri(10, 7); set_pri(20, 2);
        drive_src((64'h1 << 3) | (64'h1 << 10) | (64'h1 << 20));
        chk("R5 irq masked prio", 32'(irq), 1);
        wr_reg(10'h004, 32'h1F);
        rd_chk("R6 tie higher", 10'h040, 32'h000A_0000);
        drive_src((64'h1 << 3) | (64'h1 << 20));
        rd_chk("R6 prio wins", 10'h040, 32'h0003_0000);
        drive_src(64'h1 << 20);
        rd_chk("R6 single", 10'h040, 32'h0014_0000);
        chk("R5 irq one", 32'(irq), 1);
        drive_src(64'h1 << 7);
        chk("R5 disabled line", 32'(irq), 0);
        rd_chk("R6 none", 10'h040, 32'hFFFF_0000);
    endtask

    task automatic t_mask();
        drive_src((64'h1 << 3) | (64'h1 << 20));
        wr_reg(10'h004, 5);
        rd_chk("R7 thr5", 10'h040, 32'h0003_0000);
        wr_reg(10'h004, 7);
        chk("R7 thr7 irq", 32'(irq), 0);
        rd_chk("R7 thr7 stat", 10'h040, 32'hFFFF_0000);
        wr_reg(10'h004, 1);
        drive_src(64'h1 << 20);
        chk("R7 thr1 irq", 32'(irq), 1);
        wr_reg(10'h004, 2);
        chk("R7 equal blocked", 32'(irq), 0);
        wr_reg(10'h004, 32'h1F);
    endtask

    task automatic t_vectors_fast();
        wr_reg(10'h100 + 10'(4*3), 32'hCAFE_0003);
        wr_reg(10'h100 + 10'(4*20), 32'hBEEF_0020);
        wr_reg(10'h100 + 10'(4*40), 32'h1234_0040);
        rd_chk("R9 entry20", 10'h150, 32'hBEEF_0020);
        rd_chk("R9 entry40", 10'h1A0, 32'h1234_0040);
        drive_src(64'h1 << 20);
        rd_chk("R10 ctrl off", 10'h048, 0);
        wr_reg(10'h000, 1);
        rd_chk("R10 ctrl on", 10'h048, 32'hBEEF_0020);
        wr_reg(10'h018, 32'h0000_0100);
        wr_reg(10'h01C, 32'h0000_0008);
        wr_reg(10'h008, 40);
        drive_src((64'h1 << 3) | (64'h1 << 20) | (64'h1 << 40));
        chk("R8 fiq", 32'(fiq), 1);
        rd_chk("R8 fstat top", 10'h044, 32'd40);
        rd_chk("R6 fast excluded", 10'h040, 32'h0014_0000);
        rd_chk("R10 fast vec", 10'h04C, 32'h1234_0040);
        wr_reg(10'h00C, 40);
        rd_chk("R8 fstat next", 10'h044, 32'd3);
        rd_chk("R10 fast vec3", 10'h04C, 32'hCAFE_0003);
        drive_src('0);
        chk("R8 fiq off", 32'(fiq), 0);
        rd_chk("R10 none", 10'h04C, 0);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) pri_sh[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_type_ctrl();
        t_prio();
        t_arb();
        t_mask();
        t_vectors_fast();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule